// File: doc/BRIEF.md
# Sine Waveform Synthesizer with Programmable Start Phase

This block produces a stream of signed sine samples from a 32-bit phase accumulator. Every enabled clock the accumulator advances by a run-time frequency control word and wraps modulo 2^32. The output frequency is therefore `fcw / 2^32` times the clock rate. A run-time start-phase word is added to the accumulator before the table lookup. Several instances that share a control word can then run phase-locked with fixed mutual shifts, for example two channels in antiphase.

The upper 13 bits of the phase sum address one full sine period of 8192 points, each a 14-bit two's-complement sample. The lower 19 bits are truncated. Storage holds only the first quarter of the period plus its peak point, and the table is computed by a constant function.

The folding logic decodes the top two address bits into one of four named quadrant states:

| Quadrant | Top address bits | Table index | Sign |
|---|---|---|---|
| `QD_POS_RISE` | 00 | walks up | positive |
| `QD_POS_FALL` | 01 | walks down from the peak | positive |
| `QD_NEG_FALL` | 10 | walks up | negated |
| `QD_NEG_RISE` | 11 | walks down | negated |

The quadrant decode follows the fixed order 00, 01, 10, 11. It moves to the next quadrant each time the address crosses a quarter boundary, and wraps from `QD_NEG_RISE` back to `QD_POS_RISE`. The table read register has no reset, so it maps onto block memory. A sawtooth made of the upper 14 accumulator bits is provided as an alternative output, aligned with the sine.

Top module: `dds_sine_gen`

## Requirements
- R1: While `en_i` is high at a clock edge, the accumulator becomes (accumulator + `fcw_i`) mod 2^32.
- R2: While `en_i` is low at a clock edge, the accumulator keeps its value, so `saw_o` one cycle later is unchanged.
- R3: The lookup address is bits 31..19 of (accumulator + `phase_off_i`) mod 2^32. Bits 18..0 of that sum have no effect on `sample_o`.
- R4: The sample for address k is round(8191·sin(2πk/8192)), within one LSB, as 14-bit two's complement. The value never equals −8192.
- R5: `sample_o` and `saw_o` show the address and accumulator as they were one clock earlier. `valid_o` equals `en_i` delayed by one clock and is 0 after reset.
- R6: A synchronous reset clears the accumulator to 0. The first address after reset is therefore set by `phase_off_i` alone, and `saw_o` reads 0 right after reset.
- R7: `saw_o` equals accumulator bits 31..18, taken without the start phase.
- R8: Two instances with equal control words whose start phases differ by 0x80000000 produce samples that are exact negatives of each other.
- R9: A control word of 0x028F5C28 gives a period of 100 samples: 10 rising zero crossings in 1000 samples.
- R10: A new `fcw_i` or `phase_off_i` takes effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Advance the accumulator |
| fcw_i | input | 32 | Frequency control word |
| phase_off_i | input | 32 | Start-phase word added before lookup |
| sample_o | output | 14 | Signed sine sample |
| saw_o | output | 14 | Upper accumulator bits (sawtooth) |
| valid_o | output | 1 | `en_i` delayed one clock |

## Verification
The bench builds the block with its default parameters: a 32-bit accumulator, a 13-bit address and 14-bit samples. The bench drives a control word of exactly one address step (2^19), which walks all 8192 addresses in 8192 cycles. Every table point is therefore compared with the arithmetic sine, and each quadrant fold is taken in both directions, including both peaks and all zero points. A second instance offset by half a turn makes the antiphase property an exact per-sample comparison over the whole sweep.

// File: rtl/dds_pkg.sv
package dds_pkg;

    // Quadrant of the sine period, decoded from the top two address bits.
    typedef enum logic [1:0] {
        QD_POS_RISE = 2'd0,
        QD_POS_FALL = 2'd1,
        QD_NEG_FALL = 2'd2,
        QD_NEG_RISE = 2'd3
    } quad_e;

    localparam real TWO_PI = 6.283185307179586;

    // Magnitude of a first-quarter table point: round(peak * sin(2*pi*idx/2^addr_w)).
    function automatic int quarter_mag(input int idx, input int addr_w, input int amp_w);
        real peak;
        real ang;
        peak = real'((1 << (amp_w - 1)) - 1);
        ang  = TWO_PI * real'(idx) / real'(1 << addr_w);
        return $rtoi(peak * $sin(ang) + 0.5);
    endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int ACC_W  = 32,
    parameter int ADDR_W = 13,
    parameter int SAW_W  = 14
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  logic [ACC_W-1:0]  fcw_i,
    input  logic [ACC_W-1:0]  phase_off_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [SAW_W-1:0]  saw_o
);

    localparam int TRUNC = ACC_W - ADDR_W;

    logic [ACC_W-1:0] acc_q;

    // Accumulator register, wraps modulo 2^ACC_W.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            acc_q <= '0;
        end else if (en_i) begin
            acc_q <= acc_q + fcw_i;
        end
    end

    // Start phase applied on the address path only; low bits truncated.
    assign addr_o = ADDR_W'((acc_q + phase_off_i) >> TRUNC);
    assign saw_o  = acc_q[ACC_W-1 -: SAW_W];

endmodule

// File: rtl/dds_quarter_rom.sv
module dds_quarter_rom
    import dds_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int AMP_W  = 14
) (
    input  logic                    clk_i,
    input  logic [ADDR_W-1:0]       addr_i,
    output logic signed [AMP_W-1:0] sample_o
);

    localparam int IDX_W = ADDR_W - 2;
    localparam int QTR   = 1 << IDX_W;
    localparam int DEPTH = QTR + 1;
    localparam int MAG_W = AMP_W - 1;

    logic [MAG_W-1:0] tbl [DEPTH];

    // Quarter-period table, peak point included, computed at elaboration.
    for (genvar i = 0; i < DEPTH; i++) begin : g_tbl
        assign tbl[i] = MAG_W'(quarter_mag(i, ADDR_W, AMP_W));
    end

    quad_e            quad;
    logic [IDX_W-1:0] idx;
    logic [IDX_W:0]   tbl_idx;
    logic             neg;

    always_comb begin
        quad = quad_e'(addr_i[ADDR_W-1 -: 2]);
        idx  = addr_i[IDX_W-1:0];
        unique case (quad)
            QD_POS_RISE: begin
                tbl_idx = {1'b0, idx};
                neg     = 1'b0;
            end
            QD_POS_FALL: begin
                tbl_idx = (IDX_W+1)'(QTR) - {1'b0, idx};
                neg     = 1'b0;
            end
            QD_NEG_FALL: begin
                tbl_idx = {1'b0, idx};
                neg     = 1'b1;
            end
            QD_NEG_RISE: begin
                tbl_idx = (IDX_W+1)'(QTR) - {1'b0, idx};
                neg     = 1'b1;
            end
        endcase
    end

    // Read register without reset so the table maps onto block memory.
    logic [MAG_W-1:0] mag_q;
    logic             neg_q;

    always_ff @(posedge clk_i) begin
        mag_q <= tbl[tbl_idx];
        neg_q <= neg;
    end

    logic signed [AMP_W-1:0] pos;
    assign pos      = {1'b0, mag_q};
    assign sample_o = neg_q ? -pos : pos;

endmodule

// File: rtl/dds_sine_gen.sv
module dds_sine_gen #(
    parameter int ACC_W  = 32,
    parameter int ADDR_W = 13,
    parameter int AMP_W  = 14
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    en_i,
    input  logic [ACC_W-1:0]        fcw_i,
    input  logic [ACC_W-1:0]        phase_off_i,
    output logic signed [AMP_W-1:0] sample_o,
    output logic [AMP_W-1:0]        saw_o,
    output logic                    valid_o
);

    logic [ADDR_W-1:0] addr;
    logic [AMP_W-1:0]  saw_d;

    dds_phase_acc #(
        .ACC_W  (ACC_W),
        .ADDR_W (ADDR_W),
        .SAW_W  (AMP_W)
    ) u_acc (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .en_i        (en_i),
        .fcw_i       (fcw_i),
        .phase_off_i (phase_off_i),
        .addr_o      (addr),
        .saw_o       (saw_d)
    );

    dds_quarter_rom #(
        .ADDR_W (ADDR_W),
        .AMP_W  (AMP_W)
    ) u_rom (
        .clk_i    (clk_i),
        .addr_i   (addr),
        .sample_o (sample_o)
    );

    // Sawtooth delayed to stay aligned with the table read.
    always_ff @(posedge clk_i) begin
        saw_o <= saw_d;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            valid_o <= 1'b0;
        end else begin
            valid_o <= en_i;
        end
    end

endmodule

// File: rtl/dds_sine_gen_chk.sv
module dds_sine_gen_chk #(
    parameter int ACC_W  = 32,
    parameter int ADDR_W = 13,
    parameter int AMP_W  = 14
) (
    input logic                    clk_i,
    input logic                    rst_i,
    input logic                    en_i,
    input logic signed [AMP_W-1:0] sample_o,
    input logic [AMP_W-1:0]        saw_o,
    input logic                    valid_o
);

    localparam logic [AMP_W-1:0] MOST_NEG = {1'b1, {(AMP_W-1){1'b0}}};

    // R5: valid tracks enable with one clock of delay.
    a_r5_valid_rise : assert property (@(posedge clk_i) disable iff (rst_i)
        en_i |=> valid_o);
    a_r5_valid_low : assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> !valid_o);

    // R2: an idle edge leaves the sawtooth unchanged one cycle later.
    a_r2_hold_saw : assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(en_i, 2) |-> $stable(saw_o));

    // R4: the most negative code is never produced.
    a_r4_no_min_code : assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> (sample_o != MOST_NEG));

    // R6: the sawtooth reads zero on the first cycle out of reset.
    a_r6_saw_cleared : assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (saw_o == '0));

endmodule

bind dds_sine_gen dds_sine_gen_chk #(
    .ACC_W  (ACC_W),
    .ADDR_W (ADDR_W),
    .AMP_W  (AMP_W)
) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .en_i     (en_i),
    .sample_o (sample_o),
    .saw_o    (saw_o),
    .valid_o  (valid_o)
);

// File: tb/dds_sine_gen_tb_top.sv
module dds_sine_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [31:0] fcw = '0;
    logic [31:0] off = '0;
    logic [31:0] off_b;

    logic signed [13:0] sample_a, sample_b;
    logic [13:0]        saw_a, saw_b;
    logic               valid_a, valid_b;

    assign off_b = off + 32'h8000_0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    dds_sine_gen dut_i (
        .clk_i(clk), .rst_i(rst), .en_i(en), .fcw_i(fcw), .phase_off_i(off),
        .sample_o(sample_a), .saw_o(saw_a), .valid_o(valid_a)
    );

    dds_sine_gen dut_b (
        .clk_i(clk), .rst_i(rst), .en_i(en), .fcw_i(fcw), .phase_off_i(off_b),
        .sample_o(sample_b), .saw_o(saw_b), .valid_o(valid_b)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [31:0] m_acc;
    int          exp_sine;
    int          exp_saw;
    bit          exp_valid;

    function automatic int ref_sine(input logic [12:0] k);
        real r;
        r = 8191.0 * $sin(6.283185307179586 * real'(k) / 8192.0);
        if (r >= 0.0) return $rtoi(r + 0.5);
        else          return -$rtoi(-r + 0.5);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge, predict, and compare at the next falling edge.
    task automatic tick(input logic e, input logic [31:0] f, input logic [31:0] o);
        logic [31:0] ph;
        int          d;
        en = e; fcw = f; off = o;
        ph        = m_acc + o;
        exp_sine  = ref_sine(ph[31:19]);
        exp_saw   = int'(m_acc[31:18]);
        exp_valid = e;
        if (e) m_acc = m_acc + f;
        @(negedge clk);
        d = int'(sample_a) - exp_sine;
        check(d >= -1 && d <= 1, "R4/R3/R10 sine value", int'(sample_a), exp_sine);
        check(sample_a != -14'sd8192, "R4 min code", int'(sample_a), -8191);
        check(int'(saw_a) == exp_saw, "R1/R7 sawtooth", int'(saw_a), exp_saw);
        check(valid_a == exp_valid, "R5 valid", int'(valid_a), int'(exp_valid));
        check(int'(sample_b) == -int'(sample_a), "R8 antiphase", int'(sample_b), -int'(sample_a));
    endtask

    task automatic do_reset();
        rst = 1'b1; en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_acc = '0;
        @(negedge clk);
        // Falling edge after a non-reset rising edge with en low.
        check(valid_a == 1'b0, "R5 valid after reset", int'(valid_a), 0);
        check(saw_a == '0, "R6 saw after reset", int'(saw_a), 0);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
            summary();
            $finish;
        end
    end

    initial begin : stim
        logic signed [13:0] s1;
        logic [13:0]        w1;
        logic [31:0]        lcg;
        int                 rises;
        logic signed [13:0] prev;

        m_acc = '0;
        do_reset();

        // R6: start phase alone picks the first address (quarter turn -> peak).
        tick(1'b0, 32'h0, 32'h4000_0000);
        check(int'(sample_a) == 8191, "R6 first address from start phase", int'(sample_a), 8191);

        // R4: exhaustive address sweep, one address step per clock.
        for (int n = 0; n < 8192; n++) begin
            tick(1'b1, 32'h0008_0000, 32'h0);
            if (n == 2048) check(int'(sample_a) == 8191, "R4 positive peak", int'(sample_a), 8191);
            if (n == 6144) check(int'(sample_a) == -8191, "R4 negative peak", int'(sample_a), -8191);
            if (n == 4096) check(int'(sample_a) == 0, "R4 half-turn zero", int'(sample_a), 0);
        end

        // R3: low 19 phase bits have no effect.
        tick(1'b0, 32'h0, 32'h1234_0000);
        s1 = sample_a;
        tick(1'b0, 32'h0, 32'h1237_FFFF);
        check(sample_a == s1, "R3 truncated bits ignored", int'(sample_a), int'(s1));

        // R2: enable low holds the accumulator despite a nonzero control word.
        tick(1'b0, 32'h1111_1111, 32'h0);
        s1 = sample_a; w1 = saw_a;
        for (int n = 0; n < 5; n++) begin
            tick(1'b0, 32'h1111_1111, 32'h0);
            check(saw_a == w1, "R2 saw held", int'(saw_a), int'(w1));
            check(sample_a == s1, "R2 sample held", int'(sample_a), int'(s1));
        end

        // R1: wrap-around with a large control word.
        for (int n = 0; n < 40; n++) tick(1'b1, 32'hF000_0001, 32'h0);

        // R9: 1/100 of the clock rate from a -90 degree start.
        do_reset();
        tick(1'b1, 32'h028F_5C28, 32'hC000_0000);
        prev  = sample_a;
        rises = 0;
        for (int n = 1; n < 1000; n++) begin
            tick(1'b1, 32'h028F_5C28, 32'hC000_0000);
            if (prev < 0 && sample_a >= 0) rises++;
            prev = sample_a;
        end
        check(rises == 10, "R9 ten periods in 1000 samples", rises, 10);

        // R10: control word and start phase changing at run time.
        lcg = 32'h1357_9BDF;
        for (int n = 0; n < 3000; n++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            tick(lcg[3] | lcg[9], lcg ^ 32'h5A5A_0000, (n % 16 == 0) ? {lcg[15:0], lcg[31:16]} : off);
        end

        done = 1;
        summary();
        $finish;
    end

endmodule